// File: doc/BRIEF.md
# Victim Replica Way Allocator

This block runs beside one slice of a distributed shared L2. The slice belongs to one tile of a tiled multiprocessor. Each line in the system has a home tile, which is taken from a few low set-index bits of its address. When the tile's L1 throws a line out, the allocator decides whether a copy of that line may be kept in the local slice. If it may, the allocator names the way that receives the copy. When the L1 misses, the allocator looks for such a copy in the local slice before the request travels to the line's home tile.

The surrounding slice logic supplies the metadata of every way in the indexed set in the same cycle as the request. This metadata is the valid bit, a bit that marks the line as a local copy rather than a home (global) line, the sharer count and the tag. The allocator answers one cycle later with single-cycle pulses. When a copy is found on a miss, the slice invalidates that way and moves the line into L1. When the local slice has no usable way, the victim leaves the tile unchanged. Ties inside a priority class are broken by a free-running pseudo-random register.

Top module: `replica_alloc`

## Requirements
- R1: The home tile of an address is the field `addr[8:6]`, that is `TILE_W` bits starting at bit `LINE_OFF`. The tag is `addr[31:14]`.
- R2: An eviction whose home tile equals `LOCAL_TILE` (default 2) never makes a copy. The response is `alloc_skip`.
- R3: An eviction from a remote home picks an invalid way whenever the set holds one.
- R4: When no way is invalid, it picks a valid global line whose sharer count is zero.
- R5: When neither of those exists, it picks a way that already holds a local copy.
- R6: A valid global line with a nonzero sharer count is never picked. If every way is such a line, the response is `alloc_skip`.
- R7: When several ways qualify in the winning class, the choice varies between requests, and the way picked is always a member of that class.
- R8: A miss whose tag equals the tag of a valid way with the copy bit set gives `rhit` with `rhit_way` naming that way. That way is the one the slice must invalidate. No forward is issued. A valid global line with an equal tag does not count as a hit.
- R9: A miss with no matching copy gives `fwd_req`, and `fwd_tile` carries the miss address's home tile.
- R10: Every response is a one-cycle pulse in the cycle after the request. At most one of `alloc_go`, `alloc_skip`, `rhit` and `fwd_req` is high in any cycle. After reset all outputs are low.
- R11: If a miss and an eviction arrive in the same cycle, only the miss is answered and the eviction is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | L1 eviction request |
| evict_addr | input | ADDR_W | Address of the evicted line |
| miss_valid | input | 1 | L1 miss request |
| miss_addr | input | ADDR_W | Address of the missing line |
| way_valid | input | WAYS | Valid bit per way of the indexed set |
| way_replica | input | WAYS | Local-copy bit per way |
| way_shr | input | WAYS*SHR_W | Sharer count per way |
| way_tag | input | WAYS*TAG_W | Tag per way |
| alloc_go | output | 1 | Copy the victim into `alloc_way` |
| alloc_skip | output | 1 | No copy is made and the victim leaves the tile |
| alloc_way | output | WAY_W | Way chosen for the copy |
| rhit | output | 1 | Local copy found on a miss |
| rhit_way | output | WAY_W | Way of the hit copy, to be invalidated |
| fwd_req | output | 1 | Send the miss to the home tile |
| fwd_tile | output | TILE_W | Home tile of the forwarded miss |

## Verification
Eviction sets are built so that the winning class holds exactly one way. Then invalid ways, free global lines and existing copies are each shown to be chosen ahead of the next class down. A fully busy set and a locally homed victim show the two ways an eviction can be declined. Misses are tried against a matching copy, against a global line with the same tag and against no match, which separates a hit from a forward. A sweep of mixed busy and copy masks checks that a shared global line is never the victim, and repeated requests to an empty set show that the random choice spreads over several ways.

// File: rtl/replica_alloc.sv
module replica_alloc #(
  parameter int N_TILES    = 8,
  parameter int LOCAL_TILE = 2,
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF   = 6,
  parameter int SET_W      = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int WAYS   = 2 * N_TILES,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TILE_W = $clog2(N_TILES),
  localparam int SHR_W  = TILE_W + 1,
  localparam int TAG_W  = ADDR_W - LINE_OFF - SET_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evict_valid,
  input  logic [ADDR_W-1:0]      evict_addr,
  input  logic                   miss_valid,
  input  logic [ADDR_W-1:0]      miss_addr,
  input  logic [WAYS-1:0]        way_valid,
  input  logic [WAYS-1:0]        way_replica,
  input  logic [WAYS*SHR_W-1:0]  way_shr,
  input  logic [WAYS*TAG_W-1:0]  way_tag,
  output logic                   alloc_go,
  output logic                   alloc_skip,
  output logic [WAY_W-1:0]       alloc_way,
  output logic                   rhit,
  output logic [WAY_W-1:0]       rhit_way,
  output logic                   fwd_req,
  output logic [TILE_W-1:0]      fwd_tile
);

  function automatic logic [WAY_W-1:0] pick(input logic [WAYS-1:0] m, input logic [WAY_W-1:0] s);
    logic [WAY_W-1:0] idx;
    pick = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      idx = s + WAY_W'(k);
      if (m[idx]) pick = idx;
    end
  endfunction

  logic [WAYS-1:0] free_m, idle_m, rep_m, hit_m, shared_m, cls_m;
  logic [15:0]     lfsr;
  logic [TILE_W-1:0] ev_home, ms_home;
  logic [TAG_W-1:0]  ms_tag;
  logic take_miss, take_evict, go_n, unused_bits;

  assign ev_home    = evict_addr[LINE_OFF +: TILE_W];
  assign ms_home    = miss_addr[LINE_OFF +: TILE_W];
  assign ms_tag     = miss_addr[ADDR_W-1 -: TAG_W];
  assign take_miss  = miss_valid;
  assign take_evict = evict_valid & ~miss_valid;
  assign unused_bits = ^{evict_addr[ADDR_W-1:LINE_OFF+TILE_W], evict_addr[LINE_OFF-1:0],
                         miss_addr[LINE_OFF+SET_W-1:LINE_OFF+TILE_W], miss_addr[LINE_OFF-1:0]};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic no_shr;
    assign no_shr      = way_shr[w*SHR_W +: SHR_W] == '0;
    assign free_m[w]   = ~way_valid[w];
    assign idle_m[w]   = way_valid[w] & ~way_replica[w] & no_shr;
    assign rep_m[w]    = way_valid[w] & way_replica[w];
    assign shared_m[w] = way_valid[w] & ~way_replica[w] & ~no_shr;
    assign hit_m[w]    = rep_m[w] & (way_tag[w*TAG_W +: TAG_W] == ms_tag);
  end

  assign cls_m = (|free_m) ? free_m : (|idle_m) ? idle_m : rep_m;
  assign go_n  = take_evict & (ev_home != TILE_W'(LOCAL_TILE)) & (|cls_m);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr       <= LFSR_SEED;
      alloc_go   <= 1'b0;
      alloc_skip <= 1'b0;
      alloc_way  <= '0;
      rhit       <= 1'b0;
      rhit_way   <= '0;
      fwd_req    <= 1'b0;
      fwd_tile   <= '0;
    end else begin
      lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      alloc_go   <= go_n;
      alloc_skip <= take_evict & ~go_n;
      alloc_way  <= go_n ? pick(cls_m, lfsr[WAY_W-1:0]) : '0;
      rhit       <= take_miss & (|hit_m);
      rhit_way   <= pick(hit_m, '0);
      fwd_req    <= take_miss & ~(|hit_m);
      fwd_tile   <= ms_home;
    end
  end

  logic [WAYS-1:0] shared_q, free_q;
  always_ff @(posedge clk) begin
    shared_q <= shared_m;
    free_q   <= free_m;
  end

  // R6
  no_shared_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_go |-> !shared_q[alloc_way]);
  // R3
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && (|free_q)) |-> free_q[alloc_way]);
  // R2
  local_home_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_go |-> $past(evict_addr[LINE_OFF +: TILE_W]) != TILE_W'(LOCAL_TILE));
  // R9
  fwd_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req |-> fwd_tile == $past(miss_addr[LINE_OFF +: TILE_W]));
  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alloc_go, alloc_skip, rhit, fwd_req}));
  // R11
  miss_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go || alloc_skip) |-> !$past(miss_valid));

endmodule

// File: tb/replica_alloc_bench.sv
module replica_alloc_bench;
  localparam int WAYS = 16, WAY_W = 4, TILE_W = 3, SHR_W = 4, TAG_W = 18, ADDR_W = 32;
  localparam logic [TAG_W-1:0] TREQ = 18'h2A5A5;

  logic clk = 0, rst_n = 0;
  logic evict_valid = 0, miss_valid = 0;
  logic [ADDR_W-1:0] evict_addr = '0, miss_addr = '0;
  logic [WAYS-1:0] way_valid = '0, way_replica = '0;
  logic [WAYS*SHR_W-1:0] way_shr = '0;
  logic [WAYS*TAG_W-1:0] way_tag = '0;
  logic alloc_go, alloc_skip, rhit, fwd_req;
  logic [WAY_W-1:0] alloc_way, rhit_way;
  logic [TILE_W-1:0] fwd_tile;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  replica_alloc u_replica_alloc (.*);

  typedef struct packed {
    logic        miss;
    logic [2:0]  home;
    logic [15:0] vld, rep, busy, match;
    logic [3:0]  exp;   // go, skip, hit, fwd
    logic [15:0] allow;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b0, 3'd5, 16'hFFEF, 16'h0000, 16'hFFEF, 16'h0, 4'b1000, 16'h0010}, // R3
    '{1'b0, 3'd5, 16'hFFFF, 16'h0000, 16'hFEFF, 16'h0, 4'b1000, 16'h0100}, // R4
    '{1'b0, 3'd5, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0, 4'b1000, 16'h8000}, // R5
    '{1'b0, 3'd5, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0, 4'b0100, 16'h0000}, // R6
    '{1'b0, 3'd2, 16'h0000, 16'h0000, 16'h0000, 16'h0, 4'b0100, 16'h0000}, // R2
    '{1'b1, 3'd5, 16'hFFFF, 16'h0040, 16'h0000, 16'h0040, 4'b0010, 16'h0040}, // R8
    '{1'b1, 3'd5, 16'hFFFF, 16'h0000, 16'h0000, 16'h0040, 4'b0001, 16'h0000}, // R8
    '{1'b1, 3'd7, 16'hFFFF, 16'h0003, 16'h0000, 16'h0000, 4'b0001, 16'h0000}, // R9
    '{1'b0, 3'd1, 16'hFFF7, 16'h1000, 16'hEDF7, 16'h0, 4'b1000, 16'h0008}, // R3
    '{1'b0, 3'd6, 16'hFFFF, 16'h0001, 16'hFBFE, 16'h0, 4'b1000, 16'h0400}  // R4
  };

  function automatic logic [ADDR_W-1:0] mk_addr(input logic [2:0] home);
    return {TREQ, 5'b10101, home, 6'b0};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic set_meta(input logic [15:0] vld, rep, busy, match);
    way_valid = vld;
    way_replica = rep;
    for (int w = 0; w < WAYS; w++) begin
      way_shr[w*SHR_W +: SHR_W] = busy[w] ? 4'd3 : 4'd0;
      way_tag[w*TAG_W +: TAG_W] = match[w] ? TREQ : (TREQ ^ 18'h1);
    end
  endtask

  task automatic issue(input bit ev, input bit ms, input logic [2:0] eh, input logic [2:0] mh);
    @(negedge clk);
    evict_valid = ev; evict_addr = mk_addr(eh);
    miss_valid = ms;  miss_addr = mk_addr(mh);
    @(negedge clk);
    evict_valid = 0; miss_valid = 0;
  endtask

  function automatic logic [15:0] allowed(input logic [15:0] vld, rep, busy);
    logic [15:0] fr, idl, rp;
    fr = ~vld; idl = vld & ~rep & ~busy; rp = vld & rep;
    return (fr != 0) ? fr : (idl != 0) ? idl : rp;
  endfunction

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] seen;
    int distinct;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check({alloc_go, alloc_skip, rhit, fwd_req} == 4'b0, "R10", "outputs after reset",
          {alloc_go, alloc_skip, rhit, fwd_req}, 0);

    for (int i = 0; i < 10; i++) begin
      set_meta(TBL[i].vld, TBL[i].rep, TBL[i].busy, TBL[i].match);
      issue(!TBL[i].miss, TBL[i].miss, TBL[i].home, TBL[i].home);
      check({alloc_go, alloc_skip, rhit, fwd_req} == TBL[i].exp, "R2-R9 vector", "outcome",
            {alloc_go, alloc_skip, rhit, fwd_req}, TBL[i].exp);
      if (TBL[i].exp[3]) check(TBL[i].allow[alloc_way], "R3/R4/R5", "alloc_way", alloc_way, TBL[i].allow);
      if (TBL[i].exp[1]) check(TBL[i].allow[rhit_way], "R8", "rhit_way", rhit_way, TBL[i].allow);
      if (TBL[i].exp[0]) check(fwd_tile == TBL[i].home, "R9 R1", "fwd_tile", fwd_tile, TBL[i].home);
      @(negedge clk);
      check({alloc_go, alloc_skip, rhit, fwd_req} == 4'b0, "R10", "pulse width",
            {alloc_go, alloc_skip, rhit, fwd_req}, 0);
    end

    // R11: simultaneous miss and eviction
    set_meta(16'h0000, 16'h0, 16'h0, 16'h0);
    issue(1'b1, 1'b1, 3'd5, 3'd4);
    check({alloc_go, alloc_skip, rhit, fwd_req} == 4'b0001, "R11", "outcome",
          {alloc_go, alloc_skip, rhit, fwd_req}, 1);
    check(fwd_tile == 3'd4, "R11", "fwd_tile", fwd_tile, 4);

    // R7: spread of random choice over an empty set
    seen = '0;
    for (int i = 0; i < 64; i++) begin
      issue(1'b1, 1'b0, 3'd6, 3'd0);
      check(alloc_go, "R7", "alloc_go", alloc_go, 1);
      seen[alloc_way] = 1'b1;
    end
    distinct = $countones(seen);
    check(distinct >= 4, "R7", "distinct ways", distinct, 4);

    // R6: sweep of mixed masks, shared globals never picked
    for (int i = 0; i < 200; i++) begin
      logic [15:0] vld, rep, busy, al;
      vld  = 16'((i * 40503) ^ 16'hFFF0) | ((i % 3 == 0) ? 16'hFFFF : 16'h0);
      rep  = 16'((i * 2654435) >> 5) & ((i % 4 == 0) ? 16'h0 : 16'hFFFF);
      busy = 16'((i * 7919) ^ 16'hF7DF) | ((i % 5 == 0) ? 16'hFFFF : 16'h0);
      al = allowed(vld, rep, busy);
      set_meta(vld, rep, busy, 16'h0);
      issue(1'b1, 1'b0, 3'd3, 3'd0);
      if (al == 0)
        check(alloc_skip && !alloc_go, "R6", "decline", {alloc_go, alloc_skip}, 1);
      else
        check(alloc_go && al[alloc_way], "R6 R7", "way in class", alloc_way, al);
    end
    finish_run();
  end
endmodule